// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Per-Port Read Latency Select

This block is a shared word store with two fully independent access ports, called left and right. In any cycle each port may read or write any word, and both may touch the same word at once. A port takes part in a cycle only when both of its selects are asserted: the active-low select must be low and the active-high select must be high. While a port is selected, a high read/write input means read and a low one means write.

Read data leaves the RAM through a registered stage. Each port has a mode input that can change from cycle to cycle. With the mode input low, the registered array word is presented directly (flow-through). With it high, one more output register is inserted (pipelined). Pads are modelled as a data bus plus a valid flag. When the output enable is inactive, the valid flag is low and the data bus reads zero. Both ports are sampled on one common clock with a synchronous active-high reset. The word count and the word width are parameters: 16 or 17 address bits give 64K or 128K words, and the width may be 8 or 9 bits.

Top module: `twin_port_ram`

## Requirements
- R1: A port is selected only while its `_sel_n` is 0 and its `_sel` is 1. A deselected port neither writes the array nor produces a valid read, whatever its `_rnw` value.
- R2: On a clock edge where a port is selected with `_rnw` = 0, its `_wdata` is stored in the word at its `_addr`.
- R3: On a clock edge where a port is selected with `_rnw` = 1, `_pipe` = 0 and `_oe_n` = 0, the port shows `_rvalid` = 1 and the addressed word on `_rdata` in the cycle that follows that edge.
- R4: If a port captured a read at one edge and sees `_pipe` = 1 and `_oe_n` = 0 at the next edge, that read's word appears with `_rvalid` = 1 in the cycle after the second edge, which is one cycle later than in R3.
- R5: After any edge at which a port samples `_oe_n` = 1, that port shows `_rvalid` = 0 and `_rdata` = 0 for the following cycle. In general, a port's output in a cycle depends on the controls it sampled at the preceding edge.
- R6: The two ports work concurrently. Both may read the same word in the same cycle, each in its own latency mode, and both get the stored value.
- R7: When both ports write the same address at the same edge, the word afterwards holds the left port's data.
- R8: A read on one port at the same edge and address as a write on the other port returns the word as it was before that write. The new value is returned by later reads.
- R9: While `rst` is 1, and in the first cycle after it falls, both ports show `_rvalid` = 0 and `_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rnw | input | 1 | Left port: 1 read, 0 write |
| l_sel_n | input | 1 | Left port select, active low |
| l_sel | input | 1 | Left port select, active high |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_pipe | input | 1 | Left port latency: 0 flow-through, 1 pipelined |
| l_rdata | output | DATA_W | Left port read data, zero when not valid |
| l_rvalid | output | 1 | Left port read data valid |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rnw | input | 1 | Right port: 1 read, 0 write |
| r_sel_n | input | 1 | Right port select, active low |
| r_sel | input | 1 | Right port select, active high |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_pipe | input | 1 | Right port latency: 0 flow-through, 1 pipelined |
| r_rdata | output | DATA_W | Right port read data, zero when not valid |
| r_rvalid | output | 1 | Right port read data valid |

## Verification
A flow-through read is due in the cycle right after the edge that captured it. A pipelined read is due one cycle after that. A write becomes visible to any read captured at a later edge, but not to a read captured at the same edge. The reference model follows these rules on every rising edge: it logs, per port, what was read at each edge together with the enable and mode sampled there, and from that log it derives the due output. The ports are then compared at the falling edge, so every result is sampled half a period after the edge that made it due, and checks are made in every cycle, including during reset.

// File: rtl/twp_pkg.sv
package twp_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;

  function automatic logic port_enabled(input logic sel_n, input logic sel);
    return (~sel_n) & sel;
  endfunction
endpackage

// File: rtl/twp_decode.sv
module twp_decode (
  input  logic                 sel_n,
  input  logic                 sel,
  input  logic                 rnw,
  input  logic                 oe_n,
  input  logic                 pipe_sel,
  output logic                 rd_req,
  output logic                 wr_req,
  output logic                 oe_act,
  output twp_pkg::lat_mode_e   lat_mode
);
  import twp_pkg::*;

  logic enabled;

  always_comb begin
    enabled  = port_enabled(sel_n, sel);
    rd_req   = enabled & rnw;
    wr_req   = enabled & ~rnw;
    oe_act   = ~oe_n;
    lat_mode = pipe_sel ? LAT_PIPE : LAT_FLOW;
  end
endmodule

// File: rtl/twp_array.sv
module twp_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [twp_pkg::NUM_PORTS-1:0]               rd_en,
  input  logic [twp_pkg::NUM_PORTS-1:0]               wr_en,
  input  logic [twp_pkg::NUM_PORTS-1:0][ADDR_W-1:0]   addr,
  input  logic [twp_pkg::NUM_PORTS-1:0][DATA_W-1:0]   wdata,
  output logic [twp_pkg::NUM_PORTS-1:0][DATA_W-1:0]   rdata
);
  import twp_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single write process: the left write is issued last, so on an address
  // clash its non-blocking update is the one that lands.
  always_ff @(posedge clk) begin
    if (wr_en[PORT_R]) mem[addr[PORT_R]] <= wdata[PORT_R];
    if (wr_en[PORT_L]) mem[addr[PORT_L]] <= wdata[PORT_L];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (rst)           rd_q <= '0;
      else if (rd_en[p]) rd_q <= mem[addr[p]];
    end
    assign rdata[p] = rd_q;
  end

  // R7
  wr_clash_left_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en[PORT_L] && wr_en[PORT_R] && addr[PORT_L] == addr[PORT_R])
      |=> mem[$past(addr[PORT_L])] == $past(wdata[PORT_L]));

  // R8
  l_read_old_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en[PORT_L] && wr_en[PORT_R] && addr[PORT_L] == addr[PORT_R])
      |=> rdata[PORT_L] == $past(mem[addr[PORT_L]]));

  // R8
  r_read_old_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en[PORT_R] && wr_en[PORT_L] && addr[PORT_L] == addr[PORT_R])
      |=> rdata[PORT_R] == $past(mem[addr[PORT_R]]));
endmodule

// File: rtl/twp_outstage.sv
module twp_outstage #(
  parameter int DATA_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req,
  input  logic                oe_act,
  input  twp_pkg::lat_mode_e  lat_mode,
  input  logic [DATA_W-1:0]   arr_q,
  output logic [DATA_W-1:0]   dout,
  output logic                dvld
);
  import twp_pkg::*;

  logic              first_v;
  logic              second_v;
  logic [DATA_W-1:0] second_d;
  logic              oe_q;
  lat_mode_e         mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_v  <= 1'b0;
      second_v <= 1'b0;
      second_d <= '0;
      oe_q     <= 1'b0;
      mode_q   <= LAT_FLOW;
    end else begin
      first_v  <= rd_req;
      second_v <= first_v;
      second_d <= arr_q;
      oe_q     <= oe_act;
      mode_q   <= lat_mode;
    end
  end

  always_comb begin
    dvld = oe_q & ((mode_q == LAT_PIPE) ? second_v : first_v);
    dout = dvld ? ((mode_q == LAT_PIPE) ? second_d : arr_q) : '0;
  end

  // R5
  oe_blanks_out_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_act |=> (!dvld && dout == '0));

  // R3
  flow_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && oe_act && lat_mode == LAT_FLOW) |=> dvld);

  // R4
  pipe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_req) && !$past(rst) && oe_act && lat_mode == LAT_PIPE)
      |=> (dvld && dout == $past(arr_q)));

  // R1
  no_read_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && lat_mode == LAT_FLOW) |=> !dvld);
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_rnw,
  input  logic              l_sel_n,
  input  logic              l_sel,
  input  logic              l_oe_n,
  input  logic              l_pipe,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_rnw,
  input  logic              r_sel_n,
  input  logic              r_sel,
  input  logic              r_oe_n,
  input  logic              r_pipe,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);
  import twp_pkg::*;

  logic [NUM_PORTS-1:0]             sel_n_v, sel_v, rnw_v, oe_n_v, pipe_v;
  logic [NUM_PORTS-1:0]             rd_v, wr_v, oe_v, vld_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, arr_q_v, dout_v;
  lat_mode_e                        mode_v [NUM_PORTS];

  assign sel_n_v = {r_sel_n, l_sel_n};
  assign sel_v   = {r_sel,   l_sel};
  assign rnw_v   = {r_rnw,   l_rnw};
  assign oe_n_v  = {r_oe_n,  l_oe_n};
  assign pipe_v  = {r_pipe,  l_pipe};
  assign addr_v  = {r_addr,  l_addr};
  assign wdata_v = {r_wdata, l_wdata};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    twp_decode u_dec (
      .sel_n    (sel_n_v[p]),
      .sel      (sel_v[p]),
      .rnw      (rnw_v[p]),
      .oe_n     (oe_n_v[p]),
      .pipe_sel (pipe_v[p]),
      .rd_req   (rd_v[p]),
      .wr_req   (wr_v[p]),
      .oe_act   (oe_v[p]),
      .lat_mode (mode_v[p])
    );

    twp_outstage #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .rd_req   (rd_v[p]),
      .oe_act   (oe_v[p]),
      .lat_mode (mode_v[p]),
      .arr_q    (arr_q_v[p]),
      .dout     (dout_v[p]),
      .dvld     (vld_v[p])
    );
  end

  twp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_v),
    .wr_en (wr_v),
    .addr  (addr_v),
    .wdata (wdata_v),
    .rdata (arr_q_v)
  );

  assign l_rdata  = dout_v[PORT_L];
  assign l_rvalid = vld_v[PORT_L];
  assign r_rdata  = dout_v[PORT_R];
  assign r_rvalid = vld_v[PORT_R];
endmodule

// File: tb/tb_twin_port_ram.sv
module tb_twin_port_ram;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DW    = 9;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic          l_rnw = 1'b1, l_sel_n = 1'b1, l_sel = 1'b0, l_oe_n = 1'b1, l_pipe = 1'b0;
  logic          r_rnw = 1'b1, r_sel_n = 1'b1, r_sel = 1'b0, r_oe_n = 1'b1, r_pipe = 1'b0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_rvalid, r_rvalid;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rnw(l_rnw), .l_sel_n(l_sel_n),
    .l_sel(l_sel), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rnw(r_rnw), .r_sel_n(r_sel_n),
    .r_sel(r_sel), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R9";
  bit    started = 1'b0;

  // Behavioural reference: a word store plus, per port, a short history of
  // what each edge read and which enable/mode it sampled.
  logic [DW-1:0] model_mem [WORDS];
  bit            rd_now  [2], rd_prev [2];
  logic [DW-1:0] dat_now [2], dat_prev[2];
  bit            oe_seen [2], pipe_seen[2];
  bit            exp_v   [2];
  logic [DW-1:0] exp_d   [2];

  always @(posedge clk) begin
    bit            sel   [2];
    bit            rnw   [2];
    logic [AW-1:0] a     [2];
    logic [DW-1:0] wd    [2];
    started = 1'b1;
    sel[0] = (l_sel_n == 1'b0) && (l_sel == 1'b1);
    sel[1] = (r_sel_n == 1'b0) && (r_sel == 1'b1);
    rnw[0] = l_rnw;   rnw[1] = r_rnw;
    a[0]   = l_addr;  a[1]   = r_addr;
    wd[0]  = l_wdata; wd[1]  = r_wdata;
    for (int p = 0; p < 2; p++) begin
      if (rst) begin
        rd_now[p] = 0; rd_prev[p] = 0; oe_seen[p] = 0; pipe_seen[p] = 0;
      end else begin
        rd_prev[p]  = rd_now[p];
        dat_prev[p] = dat_now[p];
        rd_now[p]   = sel[p] && rnw[p];
        if (rd_now[p]) dat_now[p] = model_mem[a[p]];
        oe_seen[p]   = (p == 0) ? !l_oe_n : !r_oe_n;
        pipe_seen[p] = (p == 0) ? l_pipe : r_pipe;
      end
    end
    if (!rst) begin
      if (sel[1] && !rnw[1]) model_mem[a[1]] = wd[1];
      if (sel[0] && !rnw[0]) model_mem[a[0]] = wd[0];
    end
    for (int p = 0; p < 2; p++) begin
      exp_v[p] = oe_seen[p] && (pipe_seen[p] ? rd_prev[p] : rd_now[p]);
      exp_d[p] = !exp_v[p] ? '0 : (pipe_seen[p] ? dat_prev[p] : dat_now[p]);
    end
  end

  task automatic chk(input int p, input logic av, input logic [DW-1:0] ad);
    checks++;
    if (av !== exp_v[p] || ad !== exp_d[p]) begin
      fails++;
      $display("FAIL %s port %0d: got valid=%b data=%h, expected valid=%b data=%h",
               cur_req, p, av, ad, exp_v[p], exp_d[p]);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(0, l_rvalid, l_rdata);
      chk(1, r_rvalid, r_rdata);
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 37 + salt) % (1 << DW));
  endfunction

  task automatic drv(input int p, input logic sn, input logic s, input logic rnw,
                     input int a, input logic [DW-1:0] d, input logic oen, input logic pp);
    if (p == 0) begin
      l_sel_n = sn; l_sel = s; l_rnw = rnw; l_addr = AW'(a); l_wdata = d;
      l_oe_n = oen; l_pipe = pp;
    end else begin
      r_sel_n = sn; r_sel = s; r_rnw = rnw; r_addr = AW'(a); r_wdata = d;
      r_oe_n = oen; r_pipe = pp;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    drv(0, 1, 0, 1, 0, '0, 1, 0);
    drv(1, 1, 0, 1, 0, '0, 1, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: reset holds both outputs at invalid/zero
    cur_req = "R9";
    idle();
    drv(0, 0, 1, 1, 0, '0, 0, 0);
    repeat (3) tick();
    idle();
    rst = 1'b0;
    repeat (2) tick();

    // R2: fill every word, left on even and right on odd addresses
    cur_req = "R2";
    for (int a = 0; a < WORDS / 2; a++) begin
      drv(0, 0, 1, 0, 2 * a,     pat(2 * a, 3),     1, 0);
      drv(1, 0, 1, 0, 2 * a + 1, pat(2 * a + 1, 3), 1, 0);
      tick();
    end

    // R3: flow-through reads on both ports
    cur_req = "R3";
    for (int i = 0; i < 16; i++) begin
      drv(0, 0, 1, 1, i,             '0, 0, 0);
      drv(1, 0, 1, 1, WORDS - 1 - i, '0, 0, 0);
      tick();
    end

    // R4: pipelined reads, one extra cycle of latency
    cur_req = "R4";
    for (int i = 0; i < 16; i++) begin
      drv(0, 0, 1, 1, 20 + i, '0, 0, 1);
      drv(1, 0, 1, 1, 40 - i, '0, 0, 1);
      tick();
    end

    // R6: same word read on both ports, different latency modes
    cur_req = "R6";
    for (int i = 0; i < 12; i++) begin
      drv(0, 0, 1, 1, 5 * i, '0, 0, i % 2);
      drv(1, 0, 1, 1, 5 * i, '0, 0, (i + 1) % 2);
      tick();
    end

    // R5: output enable toggling in both modes
    cur_req = "R5";
    for (int i = 0; i < 16; i++) begin
      drv(0, 0, 1, 1, i,      '0, i % 2,       i / 8);
      drv(1, 0, 1, 1, i + 30, '0, (i / 2) % 2, i / 8);
      tick();
    end

    // R7: both ports write the same word in one cycle
    cur_req = "R7";
    for (int i = 0; i < 4; i++) begin
      drv(0, 0, 1, 0, 10 + i, pat(i, 100), 1, 0);
      drv(1, 0, 1, 0, 10 + i, pat(i, 200), 1, 0);
      tick();
    end
    for (int i = 0; i < 4; i++) begin
      drv(0, 0, 1, 1, 10 + i, '0, 0, 0);
      drv(1, 0, 1, 1, 10 + i, '0, 0, 1);
      tick();
    end

    // R8: read on one port against a write on the other, same word
    cur_req = "R8";
    drv(0, 0, 1, 1, 20, '0,           0, 0);
    drv(1, 0, 1, 0, 20, pat(20, 77),  0, 0);
    tick();
    drv(0, 0, 1, 0, 21, pat(21, 88),  0, 1);
    drv(1, 0, 1, 1, 21, '0,           0, 1);
    tick();
    drv(0, 0, 1, 1, 21, '0, 0, 0);
    drv(1, 0, 1, 1, 20, '0, 0, 0);
    tick();
    idle();
    repeat (2) tick();

    // R1: each partly-selected or deselected combination ignores rnw
    cur_req = "R1";
    drv(0, 1, 1, 0, 30, 9'h1AA, 0, 0); drv(1, 1, 1, 0, 31, 9'h155, 0, 0); tick();
    drv(0, 0, 0, 0, 30, 9'h0F0, 0, 0); drv(1, 0, 0, 0, 31, 9'h00F, 0, 0); tick();
    drv(0, 1, 0, 0, 30, 9'h1FF, 0, 0); drv(1, 1, 0, 0, 31, 9'h100, 0, 0); tick();
    drv(0, 1, 1, 1, 30, '0, 0, 0);     drv(1, 0, 0, 1, 31, '0, 0, 0);     tick();
    drv(0, 0, 1, 1, 30, '0, 0, 0);     drv(1, 0, 1, 1, 31, '0, 0, 0);     tick();
    idle();
    repeat (2) tick();

    // R6: mixed concurrent traffic on both ports
    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      int la;
      int ra;
      la = int'($urandom % WORDS);
      ra = ($urandom % 4 == 0) ? la : int'($urandom % WORDS);
      drv(0, ($urandom % 5 == 0), ($urandom % 5 != 0), $urandom % 2, la,
          DW'($urandom), ($urandom % 4 == 0), $urandom % 2);
      drv(1, ($urandom % 5 == 0), ($urandom % 5 != 0), $urandom % 2, ra,
          DW'($urandom), ($urandom % 4 == 0), $urandom % 2);
      tick();
    end

    idle();
    repeat (3) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule